// File: doc/BRIEF.md
# Speculative Lock Elision Region Buffer

This block runs one speculative critical section after a lock-elision predictor decides that a lock acquire can be skipped. On `start_i` the acquiring store is dropped, not performed. Its target address and the value it would have replaced are kept, and the region opens. Inside the region every store from the core goes into a small merging write buffer. Every load records the line it touched in a read set. Loads that hit a buffered word get the buffered data forwarded. The first store to each new line raises an exclusive-ownership request, so that every written line is already owned when the region ends.

The region ends in one of two ways. It validates when the core stores the saved original value back to the lock address. That restoring store is dropped as well, and the buffered stores then drain toward the cache in allocation order. While the drain runs, snoops to written lines are held back, so other agents see the whole group change at once. The region aborts if any of the following happens:
- a remote write or invalidation hits a line in the read set;
- any remote access hits a written line;
- the core writes a different value to the lock;
- the write buffer or the read set runs out of room.

An abort throws away all tracking and tells the core to roll back.

Two ports use valid/ready handshakes:
- **Core requests.** A request transfers when `req_valid_i` and `req_ready_o` are both high. Ready is high only while the region is open, and it drops in a cycle that carries a conflicting snoop.
- **Drain.** An entry transfers when `drain_valid_o` and `drain_ready_i` are both high. While ready is low, the valid entry stays unchanged.

Snoops present a line address (address bits above the 16-byte offset) and are taken when `snp_valid_i` and `snp_ready_o` are both high.

Top module: `sle_buffer`

## Requirements
- R1: While idle, a high `start_i` opens a region. `active_o` goes high in the next cycle, `start_addr_i` and `start_old_i` are saved, and `req_ready_o` is high only while `active_o` is high.
- R2: While the region is open, `drain_valid_o` stays low, so no buffered store is visible outside.
- R3: A store to an address that is already buffered overwrites that entry instead of taking a new one. A load to a buffered address shows `fwd_hit_o`=1 with the latest data in the same cycle. A load to an unbuffered address shows `fwd_hit_o`=0.
- R4: `own_valid_o` pulses in the cycle an accepted store is the first buffered store to its 16-byte line (line = address bits [31:4]). `own_addr_o` carries that line with a zero offset. It stays low for later stores to the same line and for stores to the lock address.
- R5: A store of the saved value to the saved lock address is not buffered. It ends the region, and the buffered entries then appear on the drain port one per accepted cycle in first-allocation order. One cycle after the last one is taken (or one cycle after the restoring store when nothing is buffered), a further cycle follows, then `commit_o` pulses for one cycle.
- R6: While `drain_valid_o` is high and `drain_ready_i` is low, the drain address and data stay unchanged.
- R7: During the region, an accepted snoop aborts the region if it has `snp_write_i`=1 and hits a read-set line, or if it hits any written line. A remote read (`snp_write_i`=0) of a line that was only read does not abort.
- R8: A store to the lock address with a value other than the saved one aborts the region.
- R9: With 8 write entries, a store to a new address aborts the region, while a store to an address already held still merges without abort. With 16 read lines, a load to a new line aborts the region, while a load to an already tracked line does not.
- R10: An abort makes `abort_o` pulse for one cycle in the cycle after the offending event, and `active_o` is low in that cycle. All buffered entries and tracked lines are discarded, so a later region forwards nothing from the aborted one.
- R11: While the buffer drains, a snoop to a written line sees `snp_ready_o`=0. A snoop to any other line sees `snp_ready_o`=1.
- R12: After reset, `active_o`, `req_ready_o`, `drain_valid_o`, `commit_o` and `abort_o` are low and `snp_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Elide the current acquire and open a region |
| start_addr_i | input | 32 | Lock address of the elided acquire |
| start_old_i | input | 32 | Value the elided acquire would have overwritten |
| active_o | output | 1 | Region open |
| req_valid_i | input | 1 | Core request valid |
| req_ready_o | output | 1 | Core request accepted |
| req_we_i | input | 1 | 1 = store, 0 = load |
| req_addr_i | input | 32 | Request word address |
| req_wdata_i | input | 32 | Store data |
| fwd_hit_o | output | 1 | Request address is held in the buffer |
| fwd_data_o | output | 32 | Buffered data for the request address |
| own_valid_o | output | 1 | Exclusive-ownership request for a newly written line |
| own_addr_o | output | 32 | Line address of that request |
| snp_valid_i | input | 1 | Incoming snoop valid |
| snp_ready_o | output | 1 | Snoop accepted |
| snp_write_i | input | 1 | Snoop is a write or invalidation |
| snp_line_i | input | 28 | Snoop line address |
| drain_valid_o | output | 1 | Drain entry valid |
| drain_ready_i | input | 1 | Cache accepts drain entry |
| drain_addr_o | output | 32 | Drain address |
| drain_data_o | output | 32 | Drain data |
| commit_o | output | 1 | Region committed (pulse) |
| abort_o | output | 1 | Region aborted (pulse) |

## Verification
Some properties are checked on every cycle:
- no drain traffic while the region is open;
- the drain entry is held under back-pressure;
- snoops to the line being drained are stalled;
- ownership requests and core acceptance happen only inside a region;
- abort and commit are single, exclusive pulses.

Other behaviours need whole scenarios and only the bench shows them:
- merging and forwarding;
- which store to a line raises ownership;
- the drain order and commit timing;
- the read-versus-write conflict rules;
- the lock-clobber abort;
- both overflow limits;
- the fact that an abort leaves nothing behind.

// File: rtl/sle_pkg.sv
package sle_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SPEC  = 2'd1,
    ST_DRAIN = 2'd2
  } sle_state_e;
endpackage

// File: rtl/sle_wbuf.sv
// Merging speculative write buffer: one entry per distinct word address,
// allocated in order, read out by index for the drain.
module sle_wbuf #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int LOB   = 4,
  localparam int IW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int LW   = AW - LOB
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          hit_o,
  output logic [DW-1:0] hit_data_o,
  output logic          line_hit_o,
  input  logic [LW-1:0] snp_line_i,
  output logic          snp_hit_o,
  output logic          full_o,
  output logic [CW-1:0] cnt_o,
  input  logic [IW-1:0] rd_idx_i,
  output logic [AW-1:0] rd_addr_o,
  output logic [DW-1:0] rd_data_o
);
  logic [AW-1:0]    addr_q [DEPTH];
  logic [DW-1:0]    data_q [DEPTH];
  logic [DEPTH-1:0] vld_q;
  logic [CW-1:0]    cnt_q;
  logic [DEPTH-1:0] m_word, m_line, m_snp, m_alloc;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    assign m_word[g]  = vld_q[g] && (addr_q[g] == addr_i);
    assign m_line[g]  = vld_q[g] && (addr_q[g][AW-1:LOB] == addr_i[AW-1:LOB]);
    assign m_snp[g]   = vld_q[g] && (addr_q[g][AW-1:LOB] == snp_line_i);
    assign m_alloc[g] = (cnt_q == CW'(g));
  end

  assign hit_o      = |m_word;
  assign line_hit_o = |m_line;
  assign snp_hit_o  = |m_snp;
  assign full_o     = (cnt_q == CW'(DEPTH));
  assign cnt_o      = cnt_q;
  assign rd_addr_o  = addr_q[rd_idx_i];
  assign rd_data_o  = data_q[rd_idx_i];

  always_comb begin
    hit_data_o = '0;
    for (int i = 0; i < DEPTH; i++)
      if (m_word[i]) hit_data_o = data_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      vld_q <= '0;
      cnt_q <= '0;
    end else if (wr_en_i && !hit_o && !full_o) begin
      vld_q <= vld_q | m_alloc;
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en_i) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (m_word[i] || (!hit_o && !full_o && m_alloc[i])) begin
          addr_q[i] <= addr_i;
          data_q[i] <= wdata_i;
        end
      end
    end
  end
endmodule

// File: rtl/sle_rset.sv
// Read-line tracking set: records each distinct line loaded in the region.
module sle_rset #(
  parameter int DEPTH = 16,
  parameter int LW    = 28,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          add_en_i,
  input  logic [LW-1:0] add_line_i,
  output logic          present_o,
  output logic          full_o,
  input  logic [LW-1:0] snp_line_i,
  output logic          snp_hit_o
);
  logic [LW-1:0]    line_q [DEPTH];
  logic [DEPTH-1:0] vld_q;
  logic [CW-1:0]    cnt_q;
  logic [DEPTH-1:0] m_add, m_snp, m_alloc;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    assign m_add[g]   = vld_q[g] && (line_q[g] == add_line_i);
    assign m_snp[g]   = vld_q[g] && (line_q[g] == snp_line_i);
    assign m_alloc[g] = (cnt_q == CW'(g));
  end

  assign present_o = |m_add;
  assign snp_hit_o = |m_snp;
  assign full_o    = (cnt_q == CW'(DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      vld_q <= '0;
      cnt_q <= '0;
    end else if (add_en_i && !present_o && !full_o) begin
      vld_q <= vld_q | m_alloc;
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (add_en_i && !present_o && !full_o) begin
      for (int i = 0; i < DEPTH; i++)
        if (m_alloc[i]) line_q[i] <= add_line_i;
    end
  end
endmodule

// File: rtl/sle_buffer.sv
module sle_buffer
  import sle_pkg::*;
#(
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int LOB      = 4,
  parameter int WB_DEPTH = 8,
  parameter int RD_DEPTH = 16,
  localparam int LW      = AW - LOB,
  localparam int WIW     = $clog2(WB_DEPTH),
  localparam int WCW     = $clog2(WB_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] start_addr_i,
  input  logic [DW-1:0] start_old_i,
  output logic          active_o,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_we_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          fwd_hit_o,
  output logic [DW-1:0] fwd_data_o,
  output logic          own_valid_o,
  output logic [AW-1:0] own_addr_o,
  input  logic          snp_valid_i,
  output logic          snp_ready_o,
  input  logic          snp_write_i,
  input  logic [LW-1:0] snp_line_i,
  output logic          drain_valid_o,
  input  logic          drain_ready_i,
  output logic [AW-1:0] drain_addr_o,
  output logic [DW-1:0] drain_data_o,
  output logic          commit_o,
  output logic          abort_o
);
  sle_state_e    state_q;
  logic [AW-1:0] lock_addr_q;
  logic [DW-1:0] lock_old_q;
  logic [WCW-1:0] idx_q;
  logic          abort_q, commit_q;

  logic          in_spec, in_drain;
  logic          wb_hit, wb_line_hit, wb_snp_hit, wb_full, wb_wr;
  logic [DW-1:0] wb_hit_data;
  logic [WCW-1:0] wb_cnt;
  logic          rs_present, rs_full, rs_snp_hit, rs_add;
  logic          snp_conflict, snp_abort;
  logic          req_fire, st_lock, st_commit, st_clobber, wb_ovf, rs_ovf;
  logic          abort_ev, drain_done, clr;

  assign in_spec  = (state_q == ST_SPEC);
  assign in_drain = (state_q == ST_DRAIN);

  // Snoop side: conflicts abort while speculating, stall while draining.
  assign snp_conflict = (snp_write_i && rs_snp_hit) || wb_snp_hit;
  assign snp_abort    = in_spec && snp_valid_i && snp_conflict;
  assign snp_ready_o  = in_drain ? !wb_snp_hit : 1'b1;

  // Core side.
  assign req_ready_o = in_spec && !(snp_valid_i && snp_conflict);
  assign req_fire    = req_valid_i && req_ready_o;
  assign st_lock     = req_we_i && (req_addr_i == lock_addr_q);
  assign st_commit   = req_fire && st_lock && (req_wdata_i == lock_old_q);
  assign st_clobber  = req_fire && st_lock && (req_wdata_i != lock_old_q);
  assign wb_ovf      = req_fire && req_we_i && !st_lock && !wb_hit && wb_full;
  assign rs_ovf      = req_fire && !req_we_i && !rs_present && rs_full;
  assign wb_wr       = req_fire && req_we_i && !st_lock && !wb_ovf;
  assign rs_add      = req_fire && !req_we_i;

  assign abort_ev    = snp_abort || st_clobber || wb_ovf || rs_ovf;
  assign drain_done  = in_drain && (idx_q == wb_cnt);
  assign clr         = abort_ev || drain_done;

  assign own_valid_o = wb_wr && !wb_line_hit;
  assign own_addr_o  = {req_addr_i[AW-1:LOB], {LOB{1'b0}}};
  assign fwd_hit_o   = in_spec && wb_hit;
  assign fwd_data_o  = wb_hit_data;

  assign drain_valid_o = in_drain && (idx_q < wb_cnt);
  assign active_o      = in_spec;
  assign commit_o      = commit_q;
  assign abort_o       = abort_q;

  sle_wbuf #(
    .DEPTH(WB_DEPTH), .AW(AW), .DW(DW), .LOB(LOB)
  ) u_wbuf (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (clr),
    .wr_en_i    (wb_wr),
    .addr_i     (req_addr_i),
    .wdata_i    (req_wdata_i),
    .hit_o      (wb_hit),
    .hit_data_o (wb_hit_data),
    .line_hit_o (wb_line_hit),
    .snp_line_i (snp_line_i),
    .snp_hit_o  (wb_snp_hit),
    .full_o     (wb_full),
    .cnt_o      (wb_cnt),
    .rd_idx_i   (idx_q[WIW-1:0]),
    .rd_addr_o  (drain_addr_o),
    .rd_data_o  (drain_data_o)
  );

  sle_rset #(
    .DEPTH(RD_DEPTH), .LW(LW)
  ) u_rset (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (clr),
    .add_en_i   (rs_add),
    .add_line_i (req_addr_i[AW-1:LOB]),
    .present_o  (rs_present),
    .full_o     (rs_full),
    .snp_line_i (snp_line_i),
    .snp_hit_o  (rs_snp_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      lock_addr_q <= '0;
      lock_old_q  <= '0;
      idx_q       <= '0;
      abort_q     <= 1'b0;
      commit_q    <= 1'b0;
    end else begin
      abort_q  <= abort_ev;
      commit_q <= drain_done;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            lock_addr_q <= start_addr_i;
            lock_old_q  <= start_old_i;
            state_q     <= ST_SPEC;
          end
        end
        ST_SPEC: begin
          if (abort_ev) begin
            state_q <= ST_IDLE;
          end else if (st_commit) begin
            idx_q   <= '0;
            state_q <= ST_DRAIN;
          end
        end
        ST_DRAIN: begin
          if (drain_done)
            state_q <= ST_IDLE;
          else if (drain_ready_i)
            idx_q <= idx_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sle_buffer_chk.sv
module sle_buffer_chk #(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int LOB = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              active_o,
  input logic              req_ready_o,
  input logic              own_valid_o,
  input logic              snp_valid_i,
  input logic              snp_ready_o,
  input logic [AW-LOB-1:0] snp_line_i,
  input logic              drain_valid_o,
  input logic              drain_ready_i,
  input logic [AW-1:0]     drain_addr_o,
  input logic [DW-1:0]     drain_data_o,
  input logic              commit_o,
  input logic              abort_o
);
  a_r1_ready_in_region: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready_o |-> active_o);

  a_r2_hidden_stores: assert property (@(posedge clk) disable iff (!rst_n)
    active_o |-> !drain_valid_o);

  a_r4_own_in_region: assert property (@(posedge clk) disable iff (!rst_n)
    own_valid_o |-> active_o);

  a_r5_commit_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |-> (!active_o && !drain_valid_o && !abort_o));

  a_r6_drain_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_valid_o && !drain_ready_i) |=>
      (drain_valid_o && $stable(drain_addr_o) && $stable(drain_data_o)));

  a_r10_abort_exit: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> (!active_o && !drain_valid_o));

  a_r10_abort_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |=> !abort_o);

  a_r11_drain_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_valid_o && snp_valid_i && (snp_line_i == drain_addr_o[AW-1:LOB]))
      |-> !snp_ready_o);
endmodule

bind sle_buffer sle_buffer_chk #(.AW(AW), .DW(DW), .LOB(LOB)) u_chk (.*);

// File: tb/sle_buffer_tb.sv
module sle_buffer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 29;

  typedef struct packed {
    logic [2:0]  op;   // 0 start,1 store,2 load,3 snoop,4 drain,5 commit,6 abort
    logic [31:0] a;
    logic [31:0] d;
    logic        f;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{3'd0, 32'h100, 32'h0,  1'b0},
    '{3'd1, 32'h200, 32'h11, 1'b1},
    '{3'd1, 32'h204, 32'h22, 1'b0},
    '{3'd1, 32'h200, 32'h33, 1'b0},
    '{3'd2, 32'h200, 32'h33, 1'b1},
    '{3'd2, 32'h300, 32'h0,  1'b0},
    '{3'd3, 32'h400, 32'h0,  1'b1},
    '{3'd3, 32'h300, 32'h0,  1'b0},
    '{3'd2, 32'h100, 32'h0,  1'b0},
    '{3'd1, 32'h100, 32'h0,  1'b0},
    '{3'd4, 32'h200, 32'h33, 1'b0},
    '{3'd4, 32'h204, 32'h22, 1'b0},
    '{3'd5, 32'h0,   32'h0,  1'b0},
    '{3'd0, 32'h100, 32'h5,  1'b0},
    '{3'd1, 32'h500, 32'h1,  1'b1},
    '{3'd2, 32'h600, 32'h0,  1'b0},
    '{3'd3, 32'h608, 32'h0,  1'b1},
    '{3'd6, 32'h0,   32'h0,  1'b0},
    '{3'd0, 32'h100, 32'h5,  1'b0},
    '{3'd1, 32'h700, 32'h9,  1'b1},
    '{3'd3, 32'h704, 32'h0,  1'b0},
    '{3'd6, 32'h0,   32'h0,  1'b0},
    '{3'd0, 32'h100, 32'h5,  1'b0},
    '{3'd1, 32'h100, 32'h7,  1'b0},
    '{3'd6, 32'h0,   32'h0,  1'b0},
    '{3'd0, 32'h100, 32'h5,  1'b0},
    '{3'd2, 32'h700, 32'h0,  1'b0},
    '{3'd1, 32'h100, 32'h5,  1'b0},
    '{3'd5, 32'h0,   32'h0,  1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] start_addr_i = '0, start_old_i = '0;
  logic        active_o, req_ready_o, fwd_hit_o, own_valid_o, snp_ready_o;
  logic        req_valid_i = 1'b0, req_we_i = 1'b0;
  logic [31:0] req_addr_i = '0, req_wdata_i = '0;
  logic [31:0] fwd_data_o, own_addr_o, drain_addr_o, drain_data_o;
  logic        snp_valid_i = 1'b0, snp_write_i = 1'b0;
  logic [27:0] snp_line_i = '0;
  logic        drain_valid_o, drain_ready_i = 1'b0, commit_o, abort_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sle_buffer u_dut (.*);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle_in();
    start_i = 0; req_valid_i = 0; req_we_i = 0; snp_valid_i = 0;
    snp_write_i = 0; drain_ready_i = 0;
  endtask

  task automatic op_start(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk); idle_in();
    start_i = 1; start_addr_i = a; start_old_i = d;
    @(posedge clk);
    @(negedge clk); idle_in(); #1;
    check(active_o === 1'b1, "R1 active", 32'(active_o), 32'd1);
  endtask

  task automatic op_store(input logic [31:0] a, input logic [31:0] d, input bit own);
    @(negedge clk); idle_in();
    req_valid_i = 1; req_we_i = 1; req_addr_i = a; req_wdata_i = d; #1;
    check(req_ready_o === 1'b1, "R1 req_ready", 32'(req_ready_o), 32'd1);
    check(own_valid_o === own, "R4 own_valid", 32'(own_valid_o), 32'(own));
    if (own) check(own_addr_o === {a[31:4], 4'h0}, "R4 own_addr", own_addr_o, {a[31:4], 4'h0});
    check(drain_valid_o === 1'b0, "R2 hidden", 32'(drain_valid_o), 32'd0);
    @(posedge clk);
  endtask

  task automatic op_load(input logic [31:0] a, input logic [31:0] d, input bit hit);
    @(negedge clk); idle_in();
    req_valid_i = 1; req_we_i = 0; req_addr_i = a; #1;
    check(fwd_hit_o === hit, "R3 fwd_hit", 32'(fwd_hit_o), 32'(hit));
    if (hit) check(fwd_data_o === d, "R3 fwd_data", fwd_data_o, d);
    @(posedge clk);
  endtask

  task automatic op_snoop(input logic [31:0] a, input bit wr);
    @(negedge clk); idle_in();
    snp_valid_i = 1; snp_write_i = wr; snp_line_i = a[31:4]; #1;
    check(snp_ready_o === 1'b1, "R7 snp_ready", 32'(snp_ready_o), 32'd1);
    @(posedge clk);
  endtask

  task automatic op_drain(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk); idle_in();
    drain_ready_i = 1; #1;
    check(drain_valid_o === 1'b1, "R5 drain_valid", 32'(drain_valid_o), 32'd1);
    check(drain_addr_o === a, "R5 drain_addr", drain_addr_o, a);
    check(drain_data_o === d, "R5 drain_data", drain_data_o, d);
    @(posedge clk);
  endtask

  task automatic op_commit();
    @(negedge clk); idle_in(); #1;
    check(!drain_valid_o && !commit_o, "R5 no early commit", 32'(commit_o), 32'd0);
    @(posedge clk);
    @(negedge clk); #1;
    check(commit_o === 1'b1, "R5 commit", 32'(commit_o), 32'd1);
    check(active_o === 1'b0, "R5 idle after commit", 32'(active_o), 32'd0);
  endtask

  task automatic op_abort(input string req);
    @(negedge clk); idle_in(); #1;
    check(abort_o === 1'b1, req, 32'(abort_o), 32'd1);
    check(active_o === 1'b0, "R10 idle after abort", 32'(active_o), 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    // R12 reset state
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    check(!active_o && !req_ready_o && !drain_valid_o && !commit_o && !abort_o,
          "R12 reset outputs", 32'({active_o, req_ready_o, drain_valid_o, commit_o, abort_o}), 32'd0);
    check(snp_ready_o === 1'b1, "R12 snp_ready", 32'(snp_ready_o), 32'd1);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      case (VEC[k].op)
        3'd0: op_start(VEC[k].a, VEC[k].d);
        3'd1: op_store(VEC[k].a, VEC[k].d, VEC[k].f);
        3'd2: op_load(VEC[k].a, VEC[k].d, VEC[k].f);
        3'd3: op_snoop(VEC[k].a, VEC[k].f);
        3'd4: op_drain(VEC[k].a, VEC[k].d);
        3'd5: op_commit();
        default: op_abort("R7 R8 R10 abort pulse");
      endcase
    end

    // R9 write buffer overflow
    op_start(32'h100, 32'h0);
    for (int i = 0; i < 8; i++) op_store(32'h1000 + 32'(i) * 32'h10, 32'(i), 1'b1);
    op_store(32'h1000, 32'hAB, 1'b0);
    @(negedge clk); idle_in(); #1;
    check(active_o === 1'b1, "R9 merge when full", 32'(active_o), 32'd1);
    op_store(32'h2000, 32'h1, 1'b0);
    op_abort("R9 write overflow abort");

    // R9 read set overflow
    op_start(32'h100, 32'h0);
    for (int i = 0; i < 16; i++) op_load(32'h3000 + 32'(i) * 32'h10, 32'h0, 1'b0);
    op_load(32'h3004, 32'h0, 1'b0);
    @(negedge clk); idle_in(); #1;
    check(active_o === 1'b1, "R9 tracked line no abort", 32'(active_o), 32'd1);
    op_load(32'h4000, 32'h0, 1'b0);
    op_abort("R9 read overflow abort");

    // R6 / R11 drain back-pressure and snoop stall
    op_start(32'h100, 32'h0);
    op_store(32'h800, 32'hAA, 1'b1);
    op_store(32'h810, 32'hBB, 1'b1);
    op_store(32'h100, 32'h0, 1'b0);
    @(negedge clk); idle_in();
    snp_valid_i = 1; snp_line_i = 28'h81; #1;
    check(snp_ready_o === 1'b0, "R11 stall written line", 32'(snp_ready_o), 32'd0);
    check(drain_addr_o === 32'h800, "R6 first entry", drain_addr_o, 32'h800);
    @(posedge clk);
    @(negedge clk); idle_in();
    snp_valid_i = 1; snp_line_i = 28'h90; #1;
    check(snp_ready_o === 1'b1, "R11 other line passes", 32'(snp_ready_o), 32'd1);
    check(drain_valid_o && drain_addr_o === 32'h800 && drain_data_o === 32'hAA,
          "R6 held entry", drain_data_o, 32'hAA);
    @(posedge clk);
    op_drain(32'h800, 32'hAA);
    op_drain(32'h810, 32'hBB);
    op_commit();

    @(negedge clk); idle_in();
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule